// File: doc/BRIEF.md
# Multi-Host Coherence Directory with Back-Invalidation

This block is the coherence directory of a memory device shared by several hosts. For each cached line it keeps one entry, which holds the line's tag, a coherence state and a bit vector of the hosts holding the line. Hosts ask for a line either shared (read-only copy) or exclusive (sole ownership). The directory itself resolves conflicts. Before it grants the line, it sends back-invalidate snoops to the hosts whose copies conflict with the request. It then holds the grant until every snooped host has acknowledged.

The directory is inclusive: every line held by any host has an entry. The table is fully associative and far smaller than the address space. A request for an untracked line may find the table full. In that case an entry is reclaimed: its holders are invalidated, and the entry is reused only after they have all acknowledged. A small local array holds the data returned with each grant. Requests are handled one at a time. The request channel back-pressures with a ready signal, so a request is never lost.

Top module: `backInvDirectory`

## Requirements
- R1: While reset is held and in the first cycle after it, reqReady is 1 and rspValid is 0. snpValid is all zeros in that time.
- R2: A shared request (reqExcl=0) to a line not in the directory issues no snoop. It returns one response with rspExcl=0, rspHost equal to the requester and rspData equal to the line's word. The word of line a is ((a * 16'h0407) ^ 16'h5A5A), truncated to DATA_W bits.
- R3: A shared request to a line in the Shared state issues no snoop. It adds the requester to the sharer set and keeps every earlier sharer.
- R4: An exclusive request (reqExcl=1) to a line held by other hosts raises snpValid for one cycle. In that cycle bit h of snpValid is set for every recorded holder h except the requester, and snpAddr is the requested line.
- R5: After a snoop, the response is not given until every snooped host has pulsed its bit of snpAck.
- R6: An exclusive grant has rspExcl=1 and leaves the requester as the line's only holder.
- R7: A requester is never snooped for the line it is requesting. This covers an upgrade from shared, and a repeat request by the current owner.
- R8: A shared request to a line held Exclusive by another host snoops that owner first. The requester then becomes the only sharer.
- R9: A newly tracked line takes the lowest-numbered free entry. If no entry is free, the entry at a round-robin pointer is reclaimed. The pointer starts at entry 0 after reset and advances by one on each reclaim. All holders of the reclaimed entry are snooped, with snpAddr set to that entry's line, before the new line is granted.
- R10: Only one request is in flight. reqReady stays 0 from the cycle after acceptance until the response, and each accepted request gets exactly one response.
- R11: An exclusive request to a line not in the directory issues no snoop and grants with rspExcl=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Directory can accept a request |
| reqHost | input | HOST_W | Requesting host number |
| reqExcl | input | 1 | 1 = exclusive request, 0 = shared request |
| reqAddr | input | ADDR_W | Requested line address |
| snpValid | output | HOSTS | One-cycle back-invalidate pulse, one bit per host |
| snpAddr | output | ADDR_W | Line being invalidated |
| snpAck | input | HOSTS | Per-host invalidate acknowledgment pulse |
| rspValid | output | 1 | Grant pulse |
| rspHost | output | HOST_W | Host receiving the grant |
| rspExcl | output | 1 | 1 = ownership granted, 0 = shared copy |
| rspData | output | DATA_W | Line data |

## Verification
The assertions rely on two assumptions about the hosts. A host pulses snpAck exactly once for each snoop it receives, and only after seeing that snoop. A request is held on reqValid until it is accepted. The bench's host responder acknowledges host h a fixed h+2 cycles after the snoop pulse, so the hosts answer in a staggered order. The driver issues a new request only after the previous response, so the stimulus stays within these assumptions.

// File: rtl/dirPkg.sv
package dirPkg;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_EXC = 2'b10
  } lineState_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_LOOKUP = 2'b01,
    ST_WAIT   = 2'b10,
    ST_GRANT  = 2'b11
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic decide;
    logic grant;
  } dirStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic needSnoop;
    logic allAcked;
  } dirStatus_t;

endpackage

// File: rtl/dirCtrl.sv
module dirCtrl
  import dirPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  dirStatus_t status,
  output dirStrobe_t strobe,
  output logic       reqReady,
  output logic       rspValid
);

  ctrlState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          stateD = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        strobe.decide = 1'b1;
        stateD = status.needSnoop ? ST_WAIT : ST_GRANT;
      end
      ST_WAIT: begin
        if (status.allAcked) stateD = ST_GRANT;
      end
      ST_GRANT: begin
        strobe.grant = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign reqReady = (stateQ == ST_IDLE);
  assign rspValid = (stateQ == ST_GRANT);

endmodule

// File: rtl/dirDatapath.sv
module dirDatapath
  import dirPkg::*;
#(
  parameter int HOSTS   = 4,
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  localparam int HOST_W = $clog2(HOSTS),
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LINES  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dirStrobe_t        strobe,
  input  logic [HOST_W-1:0] reqHost,
  input  logic              reqExcl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [HOSTS-1:0]  snpAck,
  output dirStatus_t        status,
  output logic [HOSTS-1:0]  snpValid,
  output logic [ADDR_W-1:0] snpAddr,
  output logic [HOST_W-1:0] rspHost,
  output logic              rspExcl,
  output logic [DATA_W-1:0] rspData
);

  function automatic logic [DATA_W-1:0] lineWord(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] w;
    w = DATA_W'(a) * DATA_W'(16'h0407);
    return w ^ DATA_W'(16'h5A5A);
  endfunction

  // captured request
  logic [HOST_W-1:0] curHostQ;
  logic              curExclQ;
  logic [ADDR_W-1:0] curAddrQ;

  // directory table
  logic [ADDR_W-1:0] tagQ   [ENTRIES];
  lineState_e        stQ    [ENTRIES];
  logic [HOSTS-1:0]  shQ    [ENTRIES];
  logic [IDX_W-1:0]  rrQ;
  logic [IDX_W-1:0]  selIdxQ;
  logic              appendQ;

  // snoop round
  logic [HOSTS-1:0]  pendQ;
  logic [HOSTS-1:0]  snpValidQ;
  logic [ADDR_W-1:0] snpAddrQ;

  // data store
  logic [DATA_W-1:0] memQ [LINES];

  // lookup
  logic              hit, freeAny, evict;
  logic [IDX_W-1:0]  hitIdx, freeIdx, chosenIdx;
  logic [HOSTS-1:0]  reqMask, conflict;
  logic [ADDR_W-1:0] targetAddr;
  lineState_e        hitSt;
  logic [HOSTS-1:0]  hitSh;

  always_comb begin
    hit = 1'b0;
    hitIdx = '0;
    freeAny = 1'b0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (stQ[i] != LS_INV && tagQ[i] == curAddrQ) begin
        hit = 1'b1;
        hitIdx = IDX_W'(i);
      end
      if (stQ[i] == LS_INV) begin
        freeAny = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  assign reqMask = HOSTS'(1) << curHostQ;
  assign hitSt   = stQ[hitIdx];
  assign hitSh   = shQ[hitIdx];

  always_comb begin
    conflict   = '0;
    targetAddr = curAddrQ;
    evict      = 1'b0;
    chosenIdx  = freeIdx;
    if (hit) begin
      chosenIdx = hitIdx;
      if (curExclQ || hitSt == LS_EXC) conflict = hitSh & ~reqMask;
    end else if (!freeAny) begin
      chosenIdx  = rrQ;
      evict      = 1'b1;
      conflict   = shQ[rrQ];
      targetAddr = tagQ[rrQ];
    end
  end

  assign status.needSnoop = |conflict;
  assign status.allAcked  = ((pendQ & ~snpAck) == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curHostQ  <= '0;
      curExclQ  <= 1'b0;
      curAddrQ  <= '0;
      rrQ       <= '0;
      selIdxQ   <= '0;
      appendQ   <= 1'b0;
      pendQ     <= '0;
      snpValidQ <= '0;
      snpAddrQ  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tagQ[i] <= '0;
        stQ[i]  <= LS_INV;
        shQ[i]  <= '0;
      end
      for (int a = 0; a < LINES; a++) memQ[a] <= lineWord(ADDR_W'(a));
    end else begin
      snpValidQ <= '0;
      pendQ     <= pendQ & ~snpAck;
      if (strobe.capture) begin
        curHostQ <= reqHost;
        curExclQ <= reqExcl;
        curAddrQ <= reqAddr;
      end
      if (strobe.decide) begin
        selIdxQ <= chosenIdx;
        appendQ <= hit && !curExclQ && hitSt == LS_SHR;
        if (|conflict) begin
          snpValidQ <= conflict;
          pendQ     <= conflict;
          snpAddrQ  <= targetAddr;
        end
        if (evict) rrQ <= (rrQ == IDX_W'(ENTRIES - 1)) ? '0 : rrQ + IDX_W'(1);
      end
      if (strobe.grant) begin
        tagQ[selIdxQ] <= curAddrQ;
        if (curExclQ) begin
          stQ[selIdxQ] <= LS_EXC;
          shQ[selIdxQ] <= reqMask;
        end else if (appendQ) begin
          shQ[selIdxQ] <= shQ[selIdxQ] | reqMask;
        end else begin
          stQ[selIdxQ] <= LS_SHR;
          shQ[selIdxQ] <= reqMask;
        end
      end
    end
  end

  assign snpValid = snpValidQ;
  assign snpAddr  = snpAddrQ;
  assign rspHost  = curHostQ;
  assign rspExcl  = curExclQ;
  assign rspData  = memQ[curAddrQ];

endmodule

// File: rtl/backInvDirectory.sv
module backInvDirectory
  import dirPkg::*;
#(
  parameter int HOSTS   = 4,
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  localparam int HOST_W = $clog2(HOSTS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [HOST_W-1:0] reqHost,
  input  logic              reqExcl,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [HOSTS-1:0]  snpValid,
  output logic [ADDR_W-1:0] snpAddr,
  input  logic [HOSTS-1:0]  snpAck,
  output logic              rspValid,
  output logic [HOST_W-1:0] rspHost,
  output logic              rspExcl,
  output logic [DATA_W-1:0] rspData
);

  dirStrobe_t strobe;
  dirStatus_t status;

  dirCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .status   (status),
    .strobe   (strobe),
    .reqReady (reqReady),
    .rspValid (rspValid)
  );

  dirDatapath #(
    .HOSTS   (HOSTS),
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqHost  (reqHost),
    .reqExcl  (reqExcl),
    .reqAddr  (reqAddr),
    .snpAck   (snpAck),
    .status   (status),
    .snpValid (snpValid),
    .snpAddr  (snpAddr),
    .rspHost  (rspHost),
    .rspExcl  (rspExcl),
    .rspData  (rspData)
  );

endmodule

// File: rtl/backInvDirectory_checker.sv
module backInvDirectory_checker #(
  parameter int HOSTS  = 4,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  localparam int HOST_W = $clog2(HOSTS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [HOST_W-1:0] reqHost,
  input logic              reqExcl,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [HOSTS-1:0]  snpValid,
  input logic [ADDR_W-1:0] snpAddr,
  input logic [HOSTS-1:0]  snpAck,
  input logic              rspValid,
  input logic [HOST_W-1:0] rspHost,
  input logic              rspExcl,
  input logic [DATA_W-1:0] rspData
);

  logic              busyQ;
  logic [HOST_W-1:0] hostQ;
  logic              exclQ;
  logic [ADDR_W-1:0] addrQ;
  logic [HOSTS-1:0]  outQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      hostQ <= '0;
      exclQ <= 1'b0;
      addrQ <= '0;
      outQ  <= '0;
    end else begin
      outQ <= (outQ & ~snpAck) | snpValid;
      if (reqValid && reqReady) begin
        busyQ <= 1'b1;
        hostQ <= reqHost;
        exclQ <= reqExcl;
        addrQ <= reqAddr;
      end else if (rspValid) begin
        busyQ <= 1'b0;
      end
    end
  end

  assert_ready_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> !reqReady);

  assert_rsp_to_accepted_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (busyQ && rspHost == hostQ));

  assert_ready_after_rsp_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> reqReady);

  assert_acks_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (outQ == '0));

  assert_no_self_snoop_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((snpValid != '0) && snpAddr == addrQ) |-> !snpValid[hostQ]);

  assert_single_round_R4: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid != '0) |-> (busyQ && outQ == '0));

  assert_grant_kind_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspExcl == exclQ));

endmodule

bind backInvDirectory backInvDirectory_checker #(
  .HOSTS  (HOSTS),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqHost  (reqHost),
  .reqExcl  (reqExcl),
  .reqAddr  (reqAddr),
  .snpValid (snpValid),
  .snpAddr  (snpAddr),
  .snpAck   (snpAck),
  .rspValid (rspValid),
  .rspHost  (rspHost),
  .rspExcl  (rspExcl),
  .rspData  (rspData)
);

// File: tb/backInvDirectory_bench.sv
module backInvDirectory_bench;

  localparam int HOSTS  = 4;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int HOST_W = 2;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic              reqReady;
  logic [HOST_W-1:0] reqHost;
  logic              reqExcl;
  logic [ADDR_W-1:0] reqAddr;
  logic [HOSTS-1:0]  snpValid;
  logic [ADDR_W-1:0] snpAddr;
  logic [HOSTS-1:0]  snpAck;
  logic              rspValid;
  logic [HOST_W-1:0] rspHost;
  logic              rspExcl;
  logic [DATA_W-1:0] rspData;

  backInvDirectory u_backInvDirectory (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqHost(reqHost), .reqExcl(reqExcl), .reqAddr(reqAddr),
    .snpValid(snpValid), .snpAddr(snpAddr), .snpAck(snpAck),
    .rspValid(rspValid), .rspHost(rspHost), .rspExcl(rspExcl), .rspData(rspData)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [HOST_W-1:0] host;
    logic              excl;
    logic [DATA_W-1:0] data;
    string             tag;
  } rspItem_t;

  typedef struct {
    logic [HOSTS-1:0]  mask;
    logic [ADDR_W-1:0] addr;
    string             tag;
  } snpItem_t;

  rspItem_t rspQ[$];
  snpItem_t snpQ[$];
  int vectors = 0;
  int miscompares = 0;
  int ackCnt[HOSTS];

  function automatic logic [DATA_W-1:0] expWord(input int a);
    int w;
    w = ((a * 'h0407) ^ 'h5A5A) & 'hFFFF;
    return DATA_W'(w);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // host responder: host h acknowledges h+2 cycles after its snoop
  always @(negedge clk) begin
    for (int h = 0; h < HOSTS; h++) begin
      if (!rstN) begin
        ackCnt[h] = 0;
        snpAck[h] = 1'b0;
      end else begin
        snpAck[h] = 1'b0;
        if (snpValid[h]) ackCnt[h] = h + 2;
        else if (ackCnt[h] != 0) begin
          ackCnt[h]--;
          if (ackCnt[h] == 0) snpAck[h] = 1'b1;
        end
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (snpValid != '0) begin
        check(reqReady == 1'b0, "R10", "ready during snoop", 32'(reqReady), 0);
        if (snpQ.size() == 0) check(1'b0, "R4", "unexpected snoop", 32'(snpValid), 0);
        else begin
          snpItem_t s;
          s = snpQ.pop_front();
          check(snpValid == s.mask, s.tag, "snoop mask", 32'(snpValid), 32'(s.mask));
          check(snpAddr == s.addr, s.tag, "snoop addr", 32'(snpAddr), 32'(s.addr));
        end
      end
      if (rspValid) begin
        int left;
        left = 0;
        for (int h = 0; h < HOSTS; h++) left += ackCnt[h];
        check(left == 0 && snpQ.size() == 0, "R5", "grant before acks", 32'(left), 0);
        if (rspQ.size() == 0) check(1'b0, "R10", "unexpected response", 32'(rspHost), 0);
        else begin
          rspItem_t r;
          r = rspQ.pop_front();
          check(rspHost == r.host, r.tag, "rsp host", 32'(rspHost), 32'(r.host));
          check(rspExcl == r.excl, r.tag, "rsp excl", 32'(rspExcl), 32'(r.excl));
          check(rspData == r.data, r.tag, "rsp data", 32'(rspData), 32'(r.data));
        end
      end
    end
  end

  task automatic doReq(input int host, input bit excl, input int addr,
                       input logic [HOSTS-1:0] expMask, input int expSnpAddr,
                       input string snpTag, input string rspTag);
    rspItem_t r;
    if (expMask != '0) begin
      snpItem_t s;
      s.mask = expMask;
      s.addr = ADDR_W'(expSnpAddr);
      s.tag  = snpTag;
      snpQ.push_back(s);
    end
    r.host = HOST_W'(host);
    r.excl = excl;
    r.data = expWord(addr);
    r.tag  = rspTag;
    rspQ.push_back(r);
    forever begin
      @(negedge clk);
      if (reqReady) break;
    end
    reqValid = 1'b1;
    reqHost  = HOST_W'(host);
    reqExcl  = excl;
    reqAddr  = ADDR_W'(addr);
    @(negedge clk);
    reqValid = 1'b0;
    while (rspQ.size() != 0) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0;
    reqValid = 1'b0;
    reqHost = '0;
    reqExcl = 1'b0;
    reqAddr = '0;
    repeat (3) @(negedge clk);
    check(reqReady == 1'b1, "R1", "ready in reset", 32'(reqReady), 1);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1", "ready after reset", 32'(reqReady), 1);
    check(rspValid == 1'b0, "R1", "rsp after reset", 32'(rspValid), 0);
    check(snpValid == '0, "R1", "snoop after reset", 32'(snpValid), 0);

    // sharing builds up on line 5
    doReq(0, 0, 5, 4'b0000, 0, "R2", "R2");
    doReq(1, 0, 5, 4'b0000, 0, "R3", "R3");
    doReq(2, 0, 5, 4'b0000, 0, "R3", "R3");
    // exclusive: all three sharers invalidated
    doReq(3, 1, 5, 4'b0111, 5, "R4", "R6");
    // shared on Exclusive line: owner only
    doReq(1, 0, 5, 4'b1000, 5, "R6", "R8");
    // H1 is now the sole sharer
    doReq(2, 1, 5, 4'b0010, 5, "R8", "R6");
    // owner re-requests: no snoop
    doReq(2, 1, 5, 4'b0000, 0, "R7", "R7");
    // upgrade: requester not snooped
    doReq(0, 0, 9, 4'b0000, 0, "R2", "R2");
    doReq(1, 0, 9, 4'b0000, 0, "R3", "R3");
    doReq(1, 1, 9, 4'b0001, 9, "R7", "R7");
    // exclusive to an untracked line
    doReq(3, 1, 12, 4'b0000, 0, "R11", "R11");
    // fill remaining entries 3..7
    for (int i = 0; i < 5; i++) doReq(i % 4, 0, 20 + i, 4'b0000, 0, "R9", "R9");
    // full: reclaim entry 0 (line 5, owner H2)
    doReq(0, 0, 30, 4'b0100, 5, "R9", "R9");
    // reclaim entry 1 (line 9, owner H1)
    doReq(1, 0, 31, 4'b0010, 9, "R9", "R9");
    // line 5 returns: reclaim entry 2 (line 12, owner H3)
    doReq(3, 0, 5, 4'b1000, 12, "R9", "R9");
    // line 5 starts fresh with H3 as only sharer
    doReq(0, 1, 5, 4'b1000, 5, "R9", "R6");

    repeat (5) @(negedge clk);
    check(rspQ.size() == 0 && snpQ.size() == 0, "R10", "leftover expectations",
          32'(rspQ.size() + snpQ.size()), 0);
    check(reqReady == 1'b1, "R10", "ready when idle", 32'(reqReady), 1);
    summary();
    $finish;
  end

endmodule